// File: doc/BRIEF.md
# Selectable-Order Burst Address Generator

This block produces the two low address bits for a four-beat burst to a memory whose upper address bits are held outside it. A load command captures a starting offset from the external address together with the burst order and the transfer rate. When the load command is idle, the block steps through the burst. Two orders are available. The linear order counts up from the start and wraps modulo four. The interleaved order combines the start with a running beat index by bitwise XOR.

In double-rate transfers each clock carries two beats, one on the rising edge and one on the falling edge. The block therefore presents both offsets of the current pair side by side, the even beat and the odd beat. It moves to the next pair once per clock. After the fourth beat the sequence returns to the starting pair and the active flag drops. In single-rate transfers the captured offset is held on both outputs and nothing advances.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset both beat outputs are 0 and `burst_active` is 0.
- R2: A clock edge with `load_n` low captures `start_ofs`. From the next cycle of a double-rate burst (`ddr_n` low at load), `beat_even` shows beat 0 and `beat_odd` shows beat 1, with beat 0 equal to the start offset.
- R3: When `interleave` is 0 at load (linear order), beat k is (start + k) modulo 4. For example, a start of 2 gives 2,3,0,1.
- R4: When `interleave` is 1 at load (interleaved order), beat k is start XOR k. For example, a start of 1 gives 1,0,3,2.
- R5: The order is taken from `interleave` only on a load edge. Changing `interleave` during a burst has no effect on the offsets shown.
- R6: In a double-rate burst, each edge with `load_n` high moves to the next pair of beats. Pair p shows beat 2p on `beat_even` and beat 2p+1 on `beat_odd`.
- R7: `burst_active` is 1 during the two cycles that present the pairs of a double-rate burst. On the edge after the last pair, the outputs return to pair 0 and `burst_active` falls to 0.
- R8: A single-rate load (`ddr_n` high at load) drives the start offset on both outputs, keeps `burst_active` at 0, and holds those values on later edges with `load_n` high.
- R9: A load on the same edge as an advance or a wrap takes priority. The next cycle shows pair 0 of the new burst.
- R10: `start_ofs` and `ddr_n` are ignored on edges where `load_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_n | input | 1 | Low: load a new start; high: advance |
| start_ofs | input | 2 | Low address bits giving the burst start |
| interleave | input | 1 | Order select at load: 1 interleaved, 0 linear |
| ddr_n | input | 1 | Rate select at load: 0 double-rate burst, 1 single-rate |
| beat_even | output | 2 | Offset of the rising-edge beat of the current pair |
| beat_odd | output | 2 | Offset of the falling-edge beat of the current pair |
| burst_active | output | 1 | High while the pairs of a double-rate burst are presented |

## Verification
Two events can fall on one edge: a fresh load, and the step of the pair counter that would either advance within a burst or wrap it back to its start. The bench provokes this by holding `load_n` low on the edge that follows the last pair, and again on the edge that follows the first pair. It does this with a start and order that differ from those of the running burst. A correct result is pair 0 of the new burst with `burst_active` high. An output that shows the wrapped old start or the old burst's second pair counts as a mismatch.

// File: rtl/burst_pkg.sv
package burst_pkg;

  localparam int OFS_W  = 2;
  localparam int BEATS  = 1 << OFS_W;
  localparam int LANES  = 2;
  localparam int PAIRS  = BEATS / LANES;
  localparam int PAIR_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;

  typedef logic [OFS_W-1:0]  ofs_t;
  typedef logic [PAIR_W-1:0] pair_t;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  typedef struct packed {
    ofs_t   start;
    order_e order;
    logic   ddr;
    pair_t  pair;
    logic   active;
  } burst_state_t;

  function automatic ofs_t beat_ofs(ofs_t start, ofs_t idx, order_e ord);
    ofs_t r;
    if (ord == ORD_INTERLEAVE) r = start ^ idx;
    else                       r = ofs_t'(start + idx);
    return r;
  endfunction

  function automatic pair_t next_pair(pair_t p);
    return pair_t'(p + 1'b1);
  endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_n,
  input  ofs_t         start_ofs,
  input  logic         interleave,
  input  logic         ddr_n,
  output burst_state_t state,
  output logic         load_ev,
  output logic         advance_ev,
  output logic         wrap_ev
);

  localparam pair_t LAST_PAIR = pair_t'(PAIRS - 1);

  assign load_ev    = !load_n;
  assign advance_ev = load_n && state.ddr;
  assign wrap_ev    = advance_ev && (state.pair == LAST_PAIR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= '0;
    end else if (load_ev) begin
      state.start  <= start_ofs;
      state.order  <= order_e'(interleave);
      state.ddr    <= !ddr_n;
      state.pair   <= '0;
      state.active <= !ddr_n;
    end else if (advance_ev) begin
      state.pair <= next_pair(state.pair);
      if (wrap_ev) state.active <= 1'b0;
    end
  end

  // R9: a load always restarts at pair 0
  a_r9_load_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> (state.pair == '0));

  // R6: one pair step per advancing edge
  a_r6_pair_step: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && state.ddr) |=> (state.pair == next_pair($past(state.pair))));

  // R7: active drops after the last pair
  a_r7_active_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && state.active && state.pair == LAST_PAIR) |=> !state.active);

  // R5: order only changes on a load
  a_r5_order_hold: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> $stable(state.order));

  // R10: start is held without a load
  a_r10_start_hold: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> $stable(state.start));

endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  burst_state_t state,
  output ofs_t         beats [LANES]
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic LANE_BIT = ((l % 2) == 1);
    ofs_t idx;
    assign idx = ofs_t'({state.pair, LANE_BIT});
    assign beats[l] = state.ddr ? beat_ofs(state.start, idx, state.order)
                                : state.start;
  end

  // R3: in linear order the odd beat follows the even beat by one
  a_r3_linear_neighbour: assert property (@(posedge clk) disable iff (!rst_n)
    (state.ddr && state.order == ORD_LINEAR) |-> (beats[1] == ofs_t'(beats[0] + 1'b1)));

  // R4: in interleaved order a pair differs only in bit 0
  a_r4_interleave_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (state.ddr && state.order == ORD_INTERLEAVE) |-> ((beats[0] ^ beats[1]) == ofs_t'(1)));

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            load_n,
  input  logic [burst_pkg::OFS_W-1:0]     start_ofs,
  input  logic                            interleave,
  input  logic                            ddr_n,
  output logic [burst_pkg::OFS_W-1:0]     beat_even,
  output logic [burst_pkg::OFS_W-1:0]     beat_odd,
  output logic                            burst_active
);

  burst_state_t state;
  logic         load_ev;
  logic         advance_ev;
  logic         wrap_ev;
  ofs_t         beats [LANES];

  burst_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_n     (load_n),
    .start_ofs  (start_ofs),
    .interleave (interleave),
    .ddr_n      (ddr_n),
    .state      (state),
    .load_ev    (load_ev),
    .advance_ev (advance_ev),
    .wrap_ev    (wrap_ev)
  );

  burst_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .state (state),
    .beats (beats)
  );

  assign beat_even    = beats[0];
  assign beat_odd     = beats[1];
  assign burst_active = state.active;

  // R2: a double-rate load starts at the captured offset
  a_r2_load_start: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && !ddr_n) |=> (beat_even == $past(start_ofs) && burst_active));

  // R8: single-rate outputs hold without a load
  a_r8_sdr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !state.ddr) |=> ($stable(beat_even) && $stable(beat_odd) && !burst_active));

  // R7: a wrap returns to the start offset
  a_r7_wrap_start: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> (beat_even == state.start));

endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_n = 1'b1;
  logic [1:0] start_ofs = '0;
  logic       interleave = 1'b0;
  logic       ddr_n = 1'b1;
  logic [1:0] beat_even;
  logic [1:0] beat_odd;
  logic       burst_active;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  burst_addr_gen i_burst_addr_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_n       (load_n),
    .start_ofs    (start_ofs),
    .interleave   (interleave),
    .ddr_n        (ddr_n),
    .beat_even    (beat_even),
    .beat_odd     (beat_odd),
    .burst_active (burst_active)
  );

  function automatic logic [1:0] expect_beat(int s, int k, bit il);
    int v;
    if (il) v = s ^ k;
    else    v = (s + k) % 4;
    return v[1:0];
  endfunction

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load(int s, bit il, bit ddr);
    load_n = 1'b0; start_ofs = s[1:0]; interleave = il; ddr_n = !ddr;
    tick();
    load_n = 1'b1;
  endtask

  task automatic chk_pair(string req, int s, bit il, int p, bit act);
    chk({req, " even"}, beat_even, expect_beat(s, 2*p, il));
    chk({req, " odd"}, beat_odd, expect_beat(s, 2*p+1, il));
    chk({req, " active"}, burst_active, act);
  endtask

  // R1
  task automatic t_reset();
    chk("R1 even", beat_even, 0);
    chk("R1 odd", beat_odd, 0);
    chk("R1 active", burst_active, 0);
  endtask

  // R2 R3 R4 R6 R7 R10 over every start and both orders
  task automatic t_ddr_all();
    for (int il = 0; il < 2; il++) begin
      for (int s = 0; s < 4; s++) begin
        load(s, il[0], 1'b1);
        chk_pair(il ? "R2 R4 pair0" : "R2 R3 pair0", s, il[0], 0, 1'b1);
        start_ofs = ~s[1:0]; ddr_n = 1'b1;   // R10: ignored without load
        tick();
        chk_pair(il ? "R6 R4 R10 pair1" : "R6 R3 R10 pair1", s, il[0], 1, 1'b1);
        tick();
        chk_pair("R7 wrap", s, il[0], 0, 1'b0);
      end
    end
  endtask

  // R5
  task automatic t_mode_hold();
    load(1, 1'b0, 1'b1);
    interleave = 1'b1;
    tick();
    chk_pair("R5 linear kept", 1, 1'b0, 1, 1'b1);
    interleave = 1'b0;
    load(1, 1'b1, 1'b1);
    interleave = 1'b0;
    tick();
    chk_pair("R5 interleave kept", 1, 1'b1, 1, 1'b1);
  endtask

  // R8
  task automatic t_sdr();
    load(3, 1'b0, 1'b0);
    chk("R8 even", beat_even, 3);
    chk("R8 odd", beat_odd, 3);
    chk("R8 active", burst_active, 0);
    start_ofs = 2'd0; ddr_n = 1'b0;
    tick();
    tick();
    chk("R8 hold even", beat_even, 3);
    chk("R8 hold odd", beat_odd, 3);
    chk("R8 hold active", burst_active, 0);
  endtask

  // R9
  task automatic t_load_collide();
    load(0, 1'b0, 1'b1);
    tick();
    load(2, 1'b1, 1'b1);        // on the wrap edge
    chk_pair("R9 load on wrap", 2, 1'b1, 0, 1'b1);
    load(1, 1'b0, 1'b1);        // on the advance edge
    chk_pair("R9 load on advance", 1, 1'b0, 0, 1'b1);
    tick();
    chk_pair("R9 continues", 1, 1'b0, 1, 1'b1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick();
    rst_n = 1'b1;
    t_reset();
    tick();
    t_reset();
    t_ddr_all();
    t_mode_hold();
    t_sdr();
    t_load_collide();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule